// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block is a purely combinational N-bit binary adder. Per-bit generate and propagate terms are combined by a tree of two-input group cells, so that every carry is available after a logarithmic number of cell levels rather than after a ripple through all bits. The incoming carry is treated as the generate term of an imaginary bit just below bit 0. It is folded into bit 0 before the tree. After that, every tree output is a complete prefix generate reaching down to that imaginary bit.

A parameter selects one of three tree shapes. All three give identical results and differ only in logic depth, fanout and cell count:
- Dense: minimal depth, fanout of at most two, many long wires.
- Broad: minimal depth, with a fanout that doubles at each level.
- Sparse: an up-sweep followed by a down-sweep, 2·log2 N − 1 levels and far fewer cells.

Wherever a cell's group already reaches the carry-in, its propagate output would never be read. That cell is built as a generate-only cell. An unsupported width or an unknown shape code stops elaboration.

The block is intended as the carry-propagate stage of a datapath. There, the shape is picked per instance to fit the timing and area budget of the surrounding logic.

Top module: `prefix_adder`

## Requirements
- R1: `sum_o` equals the low N bits of `opnd_a + opnd_b + carry_in`, settled in the same cycle with no clock.
- R2: `carry_out` equals bit N of `opnd_a + opnd_b + carry_in`.
- R3: When every bit propagates (`opnd_a XOR opnd_b` all ones), `carry_out` equals `carry_in` and every bit of `sum_o` equals the inverse of `carry_in`.
- R4: With `TOPO` = 0 (dense), the adder meets R1 and R2 using log2 N cell levels.
- R5: With `TOPO` = 1 (broad), the adder meets R1 and R2 using log2 N cell levels.
- R6: With `TOPO` = 2 (sparse), the adder meets R1 and R2 using 2·log2 N − 1 cell levels.
- R7: When both operands are all ones, `carry_out` is 1, `sum_o[0]` equals `carry_in`, and all other sum bits are 1.
- R8: When both operands are zero, `sum_o` is `carry_in` in bit 0 and zero elsewhere, and `carry_out` is 0.
- R9: With `opnd_a` = 1, `opnd_b` all ones and `carry_in` = 0, the generate at bit 0 travels the full width: `sum_o` is zero and `carry_out` is 1.
- R10: For the same inputs and width, all three shapes produce identical `sum_o` and `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First addend |
| opnd_b | input | N | Second addend |
| carry_in | input | 1 | Incoming carry, weight 1 |
| sum_o | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of bit N−1 |

## Verification
The bench builds all three shapes at N = 16 and applies the same operands to each, so that R10 can be compared bit for bit. It also builds the sparse shape at the smallest legal width N = 4, where up-sweep and down-sweep nearly meet. The dense shape is built at N = 8. The broad shape is built at N = 64, where the fanout of the last level reaches 32 and carries cross the full operand width. Directed full-propagate, all-generate, zero and longest-chain operands are mixed with random operands at every width.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

    localparam int TOPO_DENSE  = 0;
    localparam int TOPO_BROAD  = 1;
    localparam int TOPO_SPARSE = 2;
    localparam int MAX_BITS    = 1024;

    // number of cell levels after the seed level
    function automatic int tree_levels(int topo, int lg);
        return (topo == TOPO_SPARSE) ? (2 * lg - 1) : lg;
    endfunction

    // does node idx hold a combining cell on level lvl
    function automatic bit node_combines(int topo, int lg, int lvl, int idx);
        int d;
        bit hit;
        hit = 1'b0;
        if (lvl >= 1) begin
            case (topo)
                TOPO_DENSE: begin
                    d   = 1 << (lvl - 1);
                    hit = (idx >= d);
                end
                TOPO_BROAD: begin
                    d   = 1 << (lvl - 1);
                    hit = ((idx & d) != 0);
                end
                default: begin
                    if (lvl <= lg) begin
                        d   = 1 << lvl;
                        hit = ((idx & (d - 1)) == (d - 1));
                    end else begin
                        d   = 1 << (2 * lg - lvl);
                        hit = (((idx + 1) & (d - 1)) == (d / 2)) && (idx >= d);
                    end
                end
            endcase
        end
        return hit;
    endfunction

    // lower neighbour feeding the cell at node idx
    function automatic int node_partner(int topo, int lg, int lvl, int idx);
        int d;
        int j;
        j = idx;
        if (node_combines(topo, lg, lvl, idx)) begin
            case (topo)
                TOPO_DENSE: begin
                    d = 1 << (lvl - 1);
                    j = idx - d;
                end
                TOPO_BROAD: begin
                    d = 1 << (lvl - 1);
                    j = (idx & ~(2 * d - 1)) + d - 1;
                end
                default: begin
                    if (lvl <= lg) d = 1 << lvl;
                    else           d = 1 << (2 * lg - lvl);
                    j = idx - d / 2;
                end
            endcase
        end
        return j;
    endfunction

    // lowest bit covered by the group held at node idx after level lvl
    function automatic int span_low(int topo, int n, int lg, int lvl, int idx);
        int lo [MAX_BITS];
        for (int i = 0; i < n; i++) lo[i] = i;
        for (int l = 1; l <= lvl; l++) begin
            for (int i = n - 1; i >= 0; i--) begin
                if (node_combines(topo, lg, l, i))
                    lo[i] = lo[node_partner(topo, lg, l, i)];
            end
        end
        return lo[idx];
    endfunction

endpackage

// File: rtl/prefix_bit_pg.sv
module prefix_bit_pg #(
    parameter int N = 32
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic [N-1:0] g_bit,
    output logic [N-1:0] p_bit
);
    assign g_bit = opnd_a & opnd_b;
    assign p_bit = opnd_a ^ opnd_b;
endmodule

// File: rtl/prefix_gray_cell.sv
module prefix_gray_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    output logic g_o
);
    assign g_o = g_hi | (p_hi & g_lo);
endmodule

// File: rtl/prefix_black_cell.sv
module prefix_black_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_o,
    output logic p_o
);
    assign g_o = g_hi | (p_hi & g_lo);
    assign p_o = p_hi & p_lo;
endmodule

// File: rtl/prefix_tree.sv
module prefix_tree
    import prefix_adder_pkg::*;
#(
    parameter int N    = 32,
    parameter int TOPO = TOPO_DENSE
) (
    input  logic [N-1:0] g_in,
    input  logic [N-1:1] p_in,
    output logic [N-1:0] g_out
);
    localparam int LG     = $clog2(N);
    localparam int LEVELS = tree_levels(TOPO, LG);

    for (genvar l = 0; l <= LEVELS; l++) begin : lv
        for (genvar i = 0; i < N; i++) begin : nd
            localparam int LO_HERE = span_low(TOPO, N, LG, l, i);
            localparam bit COMB    = node_combines(TOPO, LG, l, i);
            localparam int J       = node_partner(TOPO, LG, l, i);

            logic g;

            // propagate exists only while the group stops short of the carry-in
            if (LO_HERE != 0) begin : hp
                logic p;
                if (l == 0) begin : seed_p
                    assign p = p_in[i];
                end else if (COMB) begin : blk
                    prefix_black_cell u_cell (
                        .g_hi (lv[l-1].nd[i].g),
                        .p_hi (lv[l-1].nd[i].hp.p),
                        .g_lo (lv[l-1].nd[J].g),
                        .p_lo (lv[l-1].nd[J].hp.p),
                        .g_o  (g),
                        .p_o  (p)
                    );
                end else begin : pass_p
                    assign p = lv[l-1].nd[i].hp.p;
                end
            end

            if (l == 0) begin : seed_g
                assign g = g_in[i];
            end else if (COMB && (LO_HERE == 0)) begin : gry
                prefix_gray_cell u_cell (
                    .g_hi (lv[l-1].nd[i].g),
                    .p_hi (lv[l-1].nd[i].hp.p),
                    .g_lo (lv[l-1].nd[J].g),
                    .g_o  (g)
                );
            end else if (!COMB) begin : pass_g
                assign g = lv[l-1].nd[i].g;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : outp
        assign g_out[i] = lv[LEVELS].nd[i].g;
    end
endmodule

// File: rtl/prefix_sum_xor.sv
module prefix_sum_xor #(
    parameter int N = 32
) (
    input  logic [N-1:0] p_bit,
    input  logic [N-2:0] g_pre,
    input  logic         carry_in,
    output logic [N-1:0] sum_o
);
    assign sum_o = p_bit ^ {g_pre, carry_in};
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
    import prefix_adder_pkg::*;
#(
    parameter int N    = 32,
    parameter int TOPO = TOPO_DENSE
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic         carry_in,
    output logic [N-1:0] sum_o,
    output logic         carry_out
);
    if ((N < 4) || (N > MAX_BITS) || ((N & (N - 1)) != 0)) begin : bad_width
        $error("prefix_adder: N must be a power of two from 4 up");
    end
    if ((TOPO < TOPO_DENSE) || (TOPO > TOPO_SPARSE)) begin : bad_topo
        $error("prefix_adder: unknown tree shape code");
    end

    logic [N-1:0] g_bit;
    logic [N-1:0] p_bit;
    logic         g_bit0_ci;
    logic [N-1:0] g_pre;

    prefix_bit_pg #(.N(N)) u_pg (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .g_bit  (g_bit),
        .p_bit  (p_bit)
    );

    // carry-in is the generate of bit -1; fold it into bit 0
    prefix_gray_cell u_cin (
        .g_hi (g_bit[0]),
        .p_hi (p_bit[0]),
        .g_lo (carry_in),
        .g_o  (g_bit0_ci)
    );

    prefix_tree #(.N(N), .TOPO(TOPO)) u_tree (
        .g_in  ({g_bit[N-1:1], g_bit0_ci}),
        .p_in  (p_bit[N-1:1]),
        .g_out (g_pre)
    );

    prefix_sum_xor #(.N(N)) u_sum (
        .p_bit    (p_bit),
        .g_pre    (g_pre[N-2:0]),
        .carry_in (carry_in),
        .sum_o    (sum_o)
    );

    assign carry_out = g_pre[N-1];
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
    parameter int N = 32
) (
    input logic [N-1:0] opnd_a,
    input logic [N-1:0] opnd_b,
    input logic         carry_in,
    input logic [N-1:0] sum_o,
    input logic         carry_out
);
    logic [N:0] total;

    always_comb begin
        total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{N{1'b0}}, carry_in};
        if (!$isunknown({opnd_a, opnd_b, carry_in, sum_o, carry_out})) begin
            // R1 R2
            sum_total_chk: assert ({carry_out, sum_o} == total)
                else $error("sum or carry differs from operand total");
            // R3
            all_prop_chk: assert (!(&(opnd_a ^ opnd_b)) ||
                                  ((carry_out == carry_in) && (sum_o == {N{~carry_in}})))
                else $error("full propagate result wrong");
            // R7
            all_gen_chk: assert (!((&opnd_a) && (&opnd_b)) ||
                                 (carry_out && (sum_o == {{(N-1){1'b1}}, carry_in})))
                else $error("full generate result wrong");
            // R8
            zero_chk: assert (!((opnd_a == '0) && (opnd_b == '0)) ||
                              (!carry_out && (sum_o == {{(N-1){1'b0}}, carry_in})))
                else $error("zero operand result wrong");
        end
    end
endmodule

bind prefix_adder prefix_adder_chk #(.N(N)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_out (carry_out)
);

// File: tb/prefix_adder_tb.sv
`timescale 1ns/1ps
module prefix_adder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;
    logic        cin_in = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    logic [15:0] s_d16, s_b16, s_s16;
    logic        c_d16, c_b16, c_s16;
    logic [3:0]  s_s4;
    logic        c_s4;
    logic [7:0]  s_d8;
    logic        c_d8;
    logic [63:0] s_b64;
    logic        c_b64;

    prefix_adder #(.N(16), .TOPO(0)) u_dut (
        .opnd_a(a_in[15:0]), .opnd_b(b_in[15:0]), .carry_in(cin_in),
        .sum_o(s_d16), .carry_out(c_d16));
    prefix_adder #(.N(16), .TOPO(1)) u_dut_b16 (
        .opnd_a(a_in[15:0]), .opnd_b(b_in[15:0]), .carry_in(cin_in),
        .sum_o(s_b16), .carry_out(c_b16));
    prefix_adder #(.N(16), .TOPO(2)) u_dut_s16 (
        .opnd_a(a_in[15:0]), .opnd_b(b_in[15:0]), .carry_in(cin_in),
        .sum_o(s_s16), .carry_out(c_s16));
    prefix_adder #(.N(4), .TOPO(2)) u_dut_s4 (
        .opnd_a(a_in[3:0]), .opnd_b(b_in[3:0]), .carry_in(cin_in),
        .sum_o(s_s4), .carry_out(c_s4));
    prefix_adder #(.N(8), .TOPO(0)) u_dut_d8 (
        .opnd_a(a_in[7:0]), .opnd_b(b_in[7:0]), .carry_in(cin_in),
        .sum_o(s_d8), .carry_out(c_d8));
    prefix_adder #(.N(64), .TOPO(1)) u_dut_b64 (
        .opnd_a(a_in), .opnd_b(b_in), .carry_in(cin_in),
        .sum_o(s_b64), .carry_out(c_b64));

    // behavioural reference: plain wide addition of the masked operands
    task automatic check_one(string tag, int n, logic [63:0] got_s, logic got_c);
        logic [63:0] m;
        logic [64:0] t;
        m = (n == 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
        t = {1'b0, a_in & m} + {1'b0, b_in & m} + {64'd0, cin_in};
        checks++;
        if (got_s !== (t[63:0] & m)) begin
            errors++;
            $display("FAIL %s R1 N=%0d sum actual %h expected %h", tag, n, got_s, t[63:0] & m);
        end
        checks++;
        if (got_c !== t[n]) begin
            errors++;
            $display("FAIL %s R2 N=%0d carry actual %b expected %b", tag, n, got_c, t[n]);
        end
    endtask

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check_one({tag, " R4 dense16"},  16, {48'd0, s_d16}, c_d16);
        check_one({tag, " R5 broad16"},  16, {48'd0, s_b16}, c_b16);
        check_one({tag, " R6 sparse16"}, 16, {48'd0, s_s16}, c_s16);
        check_one({tag, " R6 sparse4"},   4, {60'd0, s_s4},  c_s4);
        check_one({tag, " R4 dense8"},    8, {56'd0, s_d8},  c_d8);
        check_one({tag, " R5 broad64"},  64, s_b64,          c_b64);
        // R10: shapes agree at equal width
        check_eq({tag, " R10 dense vs broad"},  {47'd0, c_d16, s_d16}, {47'd0, c_b16, s_b16});
        check_eq({tag, " R10 dense vs sparse"}, {47'd0, c_d16, s_d16}, {47'd0, c_s16, s_s16});
    endtask

    task automatic apply(logic [63:0] a, logic [63:0] b, logic c, string tag);
        @(posedge clk);
        #1;
        a_in   = a;
        b_in   = b;
        cin_in = c;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero operands give zero outputs (R8)
        check_eq("R8 idle sum", s_b64, 64'd0);
        check_eq("R8 idle carry", {63'd0, c_b64}, 64'd0);

        for (int c = 0; c < 2; c++) begin
            apply(64'd0, 64'd0, c[0], "R8 zeros");
            check_eq("R8 zeros sum16", {48'd0, s_d16}, {63'd0, c[0]});
            apply({64{1'b1}}, {64{1'b1}}, c[0], "R7 all ones");
            check_eq("R7 all ones sum16", {47'd0, c_s16, s_s16}, {47'd0, 1'b1, 15'h7fff, c[0]});
            apply({64{1'b1}}, 64'd0, c[0], "R3 propagate");
            check_eq("R3 carry64", {63'd0, c_b64}, {63'd0, c[0]});
            apply(64'hA5C3_0F96_3C5A_E187, ~64'hA5C3_0F96_3C5A_E187, c[0], "R3 mixed");
            check_eq("R3 mixed sum16", {47'd0, c_b16, s_b16}, {47'd0, c[0], {16{~c[0]}}});
        end

        apply(64'd1, {64{1'b1}}, 1'b0, "R9 longest chain");
        check_eq("R9 chain64", {63'd0, c_b64}, 64'd1);
        check_eq("R9 chain64 sum", s_b64, 64'd0);

        // one generate at each position while all higher bits propagate
        for (int k = 0; k < 64; k++) begin
            logic [63:0] hi_mask;
            hi_mask = {64{1'b1}} << k;
            apply(hi_mask, (64'd1 << k), 1'b0, "R1 walking generate");
        end

        for (int n = 0; n < 3000; n++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule